// File: doc/BRIEF.md
# Banked GPIO Controller with Edge-Detect Interrupts

This block is a memory-mapped general-purpose I/O controller for 64 or 96 pins, grouped into banks of 32. A plain 32-bit word bus reads and writes eight register groups. The map is type-major: each group holds one word per bank, placed one after another. The alternate-function group is the exception and takes two words per bank. The controller drives the output value and the output enable of every pin. It also gives each pin's 2-bit alternate-function code to the neighbouring pin multiplexer.

Each pin input passes through a two-stage synchroniser. Every pin can flag a rising edge, a falling edge or both, each with its own enable. A flagged edge sets a sticky status bit, which software clears by writing a one to it. One interrupt line is the OR of all status bits in all banks. If a new edge and a clear hit the same status bit in the same cycle, the bit stays set, so no edge is lost while software services the pin.

Top module: `banked_gpio_ctrl`

## Requirements
- R1: After reset the following are all zero: every direction bit, every output latch bit, every alternate-function field, every edge enable, every status bit, and the interrupt line.
- R2: A read of the level group returns that bank's pin inputs as seen after two clock stages of synchronisation.
- R3: A direction bit of 1 drives that pin's output enable high and 0 drives it low. The written direction word reads back unchanged.
- R4: Writing the set group forces the latch bits under each 1 to 1, and writing the clear group forces them to 0. Bits written as 0 leave the latch as it was. Both groups always read as 0.
- R5: When a pin's rising enable is 1, a 0-to-1 change of its synchronised input sets its status bit.
- R6: When a pin's falling enable is 1, a 1-to-0 change of its synchronised input sets its status bit.
- R7: A transition whose direction is not enabled for that pin leaves its status bit at 0.
- R8: A write to the status group clears each bit written as 1 and leaves each bit written as 0 unchanged. A new edge that lands in the same cycle as the clear of the same bit leaves the bit set.
- R9: The interrupt output is 1 exactly while at least one status bit in any bank is 1.
- R10: Pin p's alternate-function code sits in alternate word p/16, at bit position (p mod 16)×2. It is driven on alt_sel[2p+1:2p], and 0 means plain GPIO.
- R11: Accesses to an address past the last group, or with bus_addr[1:0] not 00, read 0 and change nothing. Writes to the level group change nothing.
- R12: The byte address of pin p's word in group g is (g×(NUM_PINS/32) + p/32)×4, and the pin occupies bit p mod 32. Group order: level 0, direction 1, set 2, clear 3, rising enable 4, falling enable 5, status 6, alternate function 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pin_in | input | NUM_PINS | Raw pin inputs |
| pin_out | output | NUM_PINS | Output latch values |
| pin_oe | output | NUM_PINS | Output enables (direction bits) |
| alt_sel | output | 2*NUM_PINS | Alternate-function code per pin |
| irq | output | 1 | Aggregated edge interrupt |

## Verification
The assertions assume the bus is quiet during reset. They also assume each write either hits one decoded word or falls outside the map, so a write strobe implies a valid group and bank. The bench drives every bus and pin input on the falling clock edge, and it keeps bus_sel low while reset is held. It times the clear that races a new edge so the write is sampled on the very edge that captures the event. For that, it counts the two synchroniser stages and the edge register from the moment the pin changes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int BANK_BITS     = 32;
   localparam int ALT_PER_WORD  = 16;
   localparam int NUM_GROUPS    = 8;

   typedef enum logic [2:0] {
      GRP_LEVEL = 3'd0,
      GRP_DIR   = 3'd1,
      GRP_SET   = 3'd2,
      GRP_CLR   = 3'd3,
      GRP_RISE  = 3'd4,
      GRP_FALL  = 3'd5,
      GRP_STAT  = 3'd6,
      GRP_ALT   = 3'd7
   } grp_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int WIDTH  = 64,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] sync_o
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_pin_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= raw_i;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
   import gpio_bank_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [BANK_BITS-1:0] smp_i,
   input  logic [BANK_BITS-1:0] rise_en_i,
   input  logic [BANK_BITS-1:0] fall_en_i,
   input  logic [BANK_BITS-1:0] clr_i,
   output logic [BANK_BITS-1:0] status_o
);
   logic [BANK_BITS-1:0] prev_q;
   logic [BANK_BITS-1:0] stat_q;
   logic [BANK_BITS-1:0] evt;

   always_comb begin
      evt = (smp_i & ~prev_q & rise_en_i) | (~smp_i & prev_q & fall_en_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         stat_q <= '0;
      end else begin
         prev_q <= smp_i;
         stat_q <= (stat_q & ~clr_i) | evt;
      end
   end

   assign status_o = stat_q;

   AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(evt)) == $past(evt)));            // R8
   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(clr_i & ~evt)) == '0));            // R8
   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i))); // R8
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q)) == (stat_q & $past(evt) & ~$past(stat_q)))); // R7
endmodule

// File: rtl/banked_gpio_ctrl.sv
module banked_gpio_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 64,
   parameter int ADDR_W   = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel,
   input  logic                  bus_we,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   input  logic [NUM_PINS-1:0]   pin_in,
   output logic [NUM_PINS-1:0]   pin_out,
   output logic [NUM_PINS-1:0]   pin_oe,
   output logic [2*NUM_PINS-1:0] alt_sel,
   output logic                  irq
);
   localparam int NB       = NUM_PINS / BANK_BITS;
   localparam int NALT     = 2 * NB;
   localparam int WORD_W   = ADDR_W - 2;
   localparam int ALT_BASE = (NUM_GROUPS - 1) * NB;
   localparam int TOTAL_W  = ALT_BASE + NALT;

   generate
      if (NUM_PINS != 64 && NUM_PINS != 96) begin : g_bad_pins
         $error("NUM_PINS must be 64 or 96");
      end
      if ((1 << WORD_W) < TOTAL_W) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   logic [WORD_W-1:0] word;
   grp_e              grp;
   int                sub;
   logic              in_rng;
   logic              wr;

   assign word = bus_addr[ADDR_W-1:2];

   always_comb begin
      int w;
      w = int'(word);
      if (w < ALT_BASE) begin
         grp = grp_e'(3'(w / NB));
         sub = w % NB;
      end else begin
         grp = GRP_ALT;
         sub = w - ALT_BASE;
      end
      in_rng = (w < TOTAL_W) && (bus_addr[1:0] == 2'b00);
   end

   assign wr = bus_sel && bus_we && in_rng;

   logic [NB-1:0]   st_dir, st_set, st_clr, st_rise, st_fall, st_stat;
   logic [NALT-1:0] st_alt;

   always_comb begin
      for (int b = 0; b < NB; b++) begin
         st_dir[b]  = wr && (grp == GRP_DIR)  && (sub == b);
         st_set[b]  = wr && (grp == GRP_SET)  && (sub == b);
         st_clr[b]  = wr && (grp == GRP_CLR)  && (sub == b);
         st_rise[b] = wr && (grp == GRP_RISE) && (sub == b);
         st_fall[b] = wr && (grp == GRP_FALL) && (sub == b);
         st_stat[b] = wr && (grp == GRP_STAT) && (sub == b);
      end
      for (int a = 0; a < NALT; a++) begin
         st_alt[a] = wr && (grp == GRP_ALT) && (sub == a);
      end
   end

   logic [NUM_PINS-1:0] sync_in;

   gpio_pin_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (pin_in),
      .sync_o (sync_in)
   );

   logic [31:0] dir_q  [NB];
   logic [31:0] out_q  [NB];
   logic [31:0] rise_q [NB];
   logic [31:0] fall_q [NB];
   logic [31:0] stat_w [NB];
   logic [31:0] alt_q  [NALT];

   genvar gb, ga;
   generate
      for (gb = 0; gb < NB; gb++) begin : g_bank
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dir_q[gb]  <= '0;
               out_q[gb]  <= '0;
               rise_q[gb] <= '0;
               fall_q[gb] <= '0;
            end else begin
               if (st_dir[gb])  dir_q[gb]  <= bus_wdata;
               if (st_rise[gb]) rise_q[gb] <= bus_wdata;
               if (st_fall[gb]) fall_q[gb] <= bus_wdata;
               if (st_set[gb])  out_q[gb]  <= out_q[gb] | bus_wdata;
               else if (st_clr[gb]) out_q[gb] <= out_q[gb] & ~bus_wdata;
            end
         end

         gpio_edge_bank u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_i     (sync_in[gb*BANK_BITS +: BANK_BITS]),
            .rise_en_i (rise_q[gb]),
            .fall_en_i (fall_q[gb]),
            .clr_i     (st_stat[gb] ? bus_wdata : 32'h0),
            .status_o  (stat_w[gb])
         );

         assign pin_out[gb*BANK_BITS +: BANK_BITS] = out_q[gb];
         assign pin_oe[gb*BANK_BITS +: BANK_BITS]  = dir_q[gb];

         AST_SET_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
            st_set[gb] |=> ((out_q[gb] & $past(bus_wdata)) == $past(bus_wdata)));   // R4
         AST_CLR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
            st_clr[gb] |=> ((out_q[gb] & $past(bus_wdata)) == '0));                 // R4
         AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !(st_set[gb] || st_clr[gb]) |=> $stable(out_q[gb]));                    // R4
      end

      for (ga = 0; ga < NALT; ga++) begin : g_alt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          alt_q[ga] <= '0;
            else if (st_alt[ga]) alt_q[ga] <= bus_wdata;
         end
         assign alt_sel[ga*BANK_BITS +: BANK_BITS] = alt_q[ga];
      end
   endgenerate

   always_comb begin
      irq = 1'b0;
      for (int b = 0; b < NB; b++) irq = irq | (|stat_w[b]);
   end

   always_comb begin
      bus_rdata = '0;
      if (in_rng) begin
         for (int b = 0; b < NB; b++) begin
            if (sub == b) begin
               case (grp)
                  GRP_LEVEL: bus_rdata = sync_in[b*BANK_BITS +: BANK_BITS];
                  GRP_DIR:   bus_rdata = dir_q[b];
                  GRP_RISE:  bus_rdata = rise_q[b];
                  GRP_FALL:  bus_rdata = fall_q[b];
                  GRP_STAT:  bus_rdata = stat_w[b];
                  default:   bus_rdata = '0;
               endcase
            end
         end
         for (int a = 0; a < NALT; a++) begin
            if (grp == GRP_ALT && sub == a) bus_rdata = alt_q[a];
         end
      end
   end

   AST_SETCLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && (grp == GRP_SET || grp == GRP_CLR)) |-> (bus_rdata == '0)); // R4
   AST_OUT_OF_MAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !in_rng) |-> (bus_rdata == '0));                                      // R11
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(|st_stat)) |=> irq);                                                    // R9
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && $stable(sync_in)) |=> !irq);                                             // R9
endmodule

// File: tb/banked_gpio_ctrl_tb.sv
`timescale 1ns/1ps
module banked_gpio_ctrl_tb;
   localparam int NP = 64;
   localparam int NB = NP / 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_we = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out;
   logic [NP-1:0] pin_oe;
   logic [2*NP-1:0] alt_sel;
   logic          irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   banked_gpio_ctrl #(.NUM_PINS(NP), .ADDR_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .alt_sel(alt_sel), .irq(irq)
   );

   // group indices: level 0, dir 1, set 2, clr 3, rise 4, fall 5, stat 6, alt 7
   function automatic logic [7:0] adr(int grp, int bank);
      return 8'((grp * NB + bank) * 4);
   endfunction

   task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 pin_oe", pin_oe, '0);
      chk("R1 pin_out", pin_out, '0);
      chk("R1 alt_sel", alt_sel, '0);
      chk("R1 irq", irq, 1'b0);
      for (int g = 1; g < 8; g++) begin
         rd(adr(g, 1), d);
         chk("R1 group word", d, 32'h0);
      end
   endtask

   task automatic t_level();
      logic [31:0] d;
      @(negedge clk);
      pin_in = 64'hDEAD_BEEF_1234_5678;
      settle();
      rd(adr(0, 0), d);
      chk("R2 level bank0", d, 32'h1234_5678);
      rd(adr(0, 1), d);
      chk("R12 level bank1", d, 32'hDEAD_BEEF);
      wr(adr(0, 0), 32'h0);
      rd(adr(0, 0), d);
      chk("R11 level write ignored", d, 32'h1234_5678);
   endtask

   task automatic t_dir();
      logic [31:0] d;
      wr(adr(1, 1), 32'hF0F0_0001);
      chk("R3 oe bank1", pin_oe, 64'hF0F0_0001_0000_0000);
      rd(adr(1, 1), d);
      chk("R3 dir readback", d, 32'hF0F0_0001);
   endtask

   task automatic t_setclr();
      logic [31:0] d;
      wr(adr(2, 0), 32'h0000_00FF);
      chk("R4 set", pin_out, 64'h0000_00FF);
      wr(adr(3, 0), 32'h0000_000F);
      chk("R4 clear", pin_out, 64'h0000_00F0);
      wr(adr(2, 0), 32'h0);
      wr(adr(3, 0), 32'h0);
      chk("R4 zero writes", pin_out, 64'h0000_00F0);
      wr(adr(2, 1), 32'h8000_0000);
      chk("R12 set bank1 pin63", pin_out, 64'h8000_0000_0000_00F0);
      rd(adr(2, 0), d);
      chk("R4 set reads 0", d, 32'h0);
      rd(adr(3, 1), d);
      chk("R4 clear reads 0", d, 32'h0);
   endtask

   task automatic t_edges();
      logic [31:0] d;
      @(negedge clk);
      pin_in = '0;
      settle();
      wr(adr(6, 0), 32'hFFFF_FFFF);
      wr(adr(6, 1), 32'hFFFF_FFFF);
      wr(adr(4, 0), 32'h0000_0008);
      wr(adr(5, 1), 32'h0000_0020);
      @(negedge clk);
      pin_in[3] = 1'b1; pin_in[4] = 1'b1;
      settle();
      rd(adr(6, 0), d);
      chk("R5 rise pin3 (R7 pin4)", d, 32'h0000_0008);
      chk("R9 irq set", irq, 1'b1);
      @(negedge clk);
      pin_in[37] = 1'b1;
      settle();
      rd(adr(6, 1), d);
      chk("R7 rise not enabled", d, 32'h0);
      @(negedge clk);
      pin_in[37] = 1'b0;
      settle();
      rd(adr(6, 1), d);
      chk("R6 fall pin37", d, 32'h0000_0020);
      wr(adr(6, 0), 32'h0000_0008);
      rd(adr(6, 0), d);
      chk("R8 w1c bank0", d, 32'h0);
      chk("R9 irq held by bank1", irq, 1'b1);
      wr(adr(6, 1), 32'h0);
      rd(adr(6, 1), d);
      chk("R8 zero write keeps", d, 32'h0000_0020);
      wr(adr(6, 1), 32'h0000_0020);
      chk("R9 irq cleared", irq, 1'b0);
   endtask

   task automatic t_race();
      logic [31:0] d;
      @(negedge clk);
      pin_in[3] = 1'b0;
      settle();
      rd(adr(6, 0), d);
      chk("R7 fall not enabled", d, 32'h0);
      @(negedge clk);
      pin_in[3] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = adr(6, 0); bus_wdata = 32'h0000_0008;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
      rd(adr(6, 0), d);
      chk("R8 edge wins over clear", d, 32'h0000_0008);
      wr(adr(6, 0), 32'h0000_0008);
   endtask

   task automatic t_alt();
      logic [31:0] d;
      wr(adr(7, 0) + 8'd4, 32'h0000_000C);
      chk("R10 pin17 code", alt_sel[35:34], 2'd3);
      wr(adr(7, 0) + 8'd12, 32'h8000_0000);
      chk("R10 pin63 code", alt_sel[127:126], 2'd2);
      chk("R10 others zero", alt_sel & ~(128'h3 << 34) & ~(128'h3 << 126), '0);
      rd(adr(7, 0) + 8'd4, d);
      chk("R10 readback", d, 32'h0000_000C);
   endtask

   task automatic t_oor();
      logic [31:0] d;
      logic [NP-1:0] oe0, out0;
      logic [2*NP-1:0] alt0;
      oe0 = pin_oe; out0 = pin_out; alt0 = alt_sel;
      wr(8'h48, 32'hFFFF_FFFF);
      wr(adr(1, 0) + 8'd1, 32'hFFFF_FFFF);
      rd(8'h48, d);
      chk("R11 past map reads 0", d, 32'h0);
      rd(8'hFC, d);
      chk("R11 top reads 0", d, 32'h0);
      rd(adr(0, 0) + 8'd2, d);
      chk("R11 unaligned reads 0", d, 32'h0);
      chk("R11 oe untouched", pin_oe, oe0);
      chk("R11 out untouched", pin_out, out0);
      chk("R11 alt untouched", alt_sel, alt0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_level();
      t_dir();
      t_setclr();
      t_edges();
      t_race();
      t_alt();
      t_oor();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule